// File: doc/BRIEF.md
# Core Priority Interrupt Controller

This block collects the interrupt requests of a processor core and offers the most urgent one to the core. The core has sixteen priority levels, numbered 0 to 15, and a lower number always wins. The chip reset owns level 0 and the non-maskable interrupt owns level 1. Levels 2 and 3 are reserved and never fire. Levels 4 to 15 come from twelve external request lines.

A rising edge on an external line or on the non-maskable line latches a pending flag. An external level is offered only when its own enable bit and a global enable bit are both set. The non-maskable level ignores both. The controller registers the winning level as a 4-bit code together with a valid flag. The core pulses acknowledge for one cycle, and this drops the pending flag of the level on offer. A small register port lets software set the enables, read the pending flags and clear external flags by writing ones.

All state and outputs are registered on the rising clock edge. The offered level is computed from the state as it stands after that same edge, so an acknowledge is followed at once by the next winner and never by a stale copy of the level just served.

Top module: `core_prio_intc`

## Requirements
- R1: After any clock edge that samples `rst` high, `req_valid_o` is 1 and `req_level_o` is 0. The same edge clears every pending flag, every enable bit, the global enable and `reg_rdata_o`.
- R2: A low-to-high change of `irq_i[k]` between two consecutive clock edges sets the pending flag of level k+4 at the second edge. A line that is held high does not set the flag again after it has been cleared.
- R3: After each edge, `req_valid_o` is 1 when any level is eligible. `req_level_o` then carries the lowest-numbered eligible level.
- R4: External level L (4 to 15) is eligible only when its flag is pending, enable bit L is set and global enable bit 0 is set. A flag that is pending but masked stays pending and is offered once it is unmasked.
- R5: A rising edge on `nmi_i` pends level 1. A pending level 1 is offered ahead of every external level, whatever the enable bits hold.
- R6: When `ack_i` is 1 at an edge while `req_valid_o` shows level 1 or a level from 4 to 15, that level's flag is cleared at that edge. An acknowledge while level 0 is shown, or while `req_valid_o` is 0, has no effect.
- R7: If a rising edge on a line meets an acknowledge or a software clear of the same level at one clock edge, the flag stays set.
- R8: A write to address 2 clears the pending flag of every level L from 4 to 15 whose data bit L is 1. Bits that are 0 leave their flags alone.
- R9: Levels 2 and 3 are never offered. Bits 0, 2 and 3 of the pending register always read as 0.
- R10: The register read port is registered. `reg_rdata_o` after an edge holds the register selected by `reg_addr_i` as it stood just before that edge. Address 0 is the enable register: bit 0 is the global enable, bits 4 to 15 are the level enables, and bits 1 to 3 read as 0. Address 1 is the pending register: bit 1 is the non-maskable flag and bits 4 to 15 are the external flags. It is read-only, so writes to it are ignored. Addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset, shown to the core as level 0 |
| nmi_i | input | 1 | Non-maskable request line, edge sensitive |
| irq_i | input | 12 | External request lines; bit k drives level k+4 |
| ack_i | input | 1 | One-cycle acknowledge of the level on offer |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| req_valid_o | output | 1 | A level is on offer to the core |
| req_level_o | output | 4 | Number of the level on offer |

## Verification
A behavioural model in the bench tracks every flag and enable and compares the outputs on every clock. Several external lines pended together show whether lower numbers truly win. Acknowledges served one after another show that each one exposes the next winner in the following cycle. The same flags pended with the enables off, with only the global bit off, and with single level bits off separate per-level masking from global masking, and they also show that the non-maskable level ignores both. Edges that land in the same cycle as an acknowledge or a software clear show which event takes precedence. Lines held high after a clear expose any level-sensitive capture.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  localparam int LVL_RESET = 0;
  localparam int LVL_NMI   = 1;
  localparam int EXT_BASE  = 4;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE  = 2'd0,
    REG_PENDING = 2'd1,
    REG_CLEAR   = 2'd2,
    REG_SPARE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpic_edge_pend.sv
module cpic_edge_pend #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] pend_nxt_o
);
  logic [N-1:0] line_q;
  logic [N-1:0] rise;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  always_ff @(posedge clk) line_q <= lines_i;

  for (genvar k = 0; k < N; k++) begin : g_cell
    assign rise[k]   = lines_i[k] & ~line_q[k];
    assign pend_d[k] = (pend_q[k] & ~clr_i[k]) | rise[k];
    always_ff @(posedge clk) begin
      if (rst) pend_q[k] <= 1'b0;
      else     pend_q[k] <= pend_d[k];
    end
  end

  assign pend_o     = pend_q;
  assign pend_nxt_o = rst ? '0 : pend_d;

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~rise)) |=> ((pend_q & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/cpic_prio_enc.sv
module cpic_prio_enc #(
  parameter int N = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      assert_winner_lowest_R3: assert (req_i[idx_o] &&
        ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/cpic_regs.sv
module cpic_regs import cpic_pkg::*; #(
  parameter int NUM_LEVELS = 16,
  localparam int N_EXT = NUM_LEVELS - EXT_BASE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic [NUM_LEVELS-1:0] wdata_i,
  input  logic [N_EXT-1:0]      pend_ext_i,
  input  logic                  nmi_pend_i,
  output logic [N_EXT-1:0]      en_o,
  output logic                  gie_o,
  output logic [N_EXT-1:0]      en_nxt_o,
  output logic                  gie_nxt_o,
  output logic [N_EXT-1:0]      sw_clr_o,
  output logic [NUM_LEVELS-1:0] rdata_o
);
  logic [N_EXT-1:0]      en_q;
  logic                  gie_q;
  logic [NUM_LEVELS-1:0] rd_d;
  logic [NUM_LEVELS-1:0] rd_q;
  reg_sel_e              sel;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    en_nxt_o  = en_q;
    gie_nxt_o = gie_q;
    sw_clr_o  = '0;
    if (wr_i) begin
      case (sel)
        REG_ENABLE: begin
          en_nxt_o  = wdata_i[NUM_LEVELS-1:EXT_BASE];
          gie_nxt_o = wdata_i[0];
        end
        REG_CLEAR: sw_clr_o = wdata_i[NUM_LEVELS-1:EXT_BASE];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    case (sel)
      REG_ENABLE:  rd_d = {en_q, {(EXT_BASE-1){1'b0}}, gie_q};
      REG_PENDING: rd_d = {pend_ext_i, {(EXT_BASE-2){1'b0}}, nmi_pend_i, 1'b0};
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      gie_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      en_q  <= en_nxt_o;
      gie_q <= gie_nxt_o;
      rd_q  <= rd_d;
    end
  end

  assign en_o    = en_q;
  assign gie_o   = gie_q;
  assign rdata_o = rd_q;

  assert_pending_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == REG_PENDING) |=> (rdata_o[0] == 1'b0 && rdata_o[3:2] == 2'b00));
endmodule

// File: rtl/core_prio_intc.sv
module core_prio_intc import cpic_pkg::*; #(
  parameter int NUM_LEVELS = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          nmi_i,
  input  logic [NUM_LEVELS-EXT_BASE-1:0] irq_i,
  input  logic                          ack_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic                          reg_wr_i,
  input  logic [NUM_LEVELS-1:0]         reg_wdata_i,
  output logic [NUM_LEVELS-1:0]         reg_rdata_o,
  output logic                          req_valid_o,
  output logic [$clog2(NUM_LEVELS)-1:0] req_level_o
);
  localparam int N_EXT = NUM_LEVELS - EXT_BASE;
  localparam int LVL_W = $clog2(NUM_LEVELS);
  localparam int IDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1;

  logic [N_EXT-1:0] pend_ext_q, pend_ext_nxt;
  logic [N_EXT-1:0] en_q, en_nxt, sw_clr, ack_ext, ext_clr, eligible;
  logic             gie_q, gie_nxt;
  logic             nmi_pend_q, nmi_pend_nxt, ack_nmi, ack_hit;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic             valid_q;
  logic [LVL_W-1:0] level_q;

  assign ack_hit = ack_i & valid_q;
  assign ack_nmi = ack_hit && (level_q == LVL_W'(LVL_NMI));

  for (genvar k = 0; k < N_EXT; k++) begin : g_ack
    assign ack_ext[k] = ack_hit && (level_q == LVL_W'(EXT_BASE + k));
  end

  assign ext_clr = sw_clr | ack_ext;

  cpic_edge_pend #(.N(N_EXT)) u_ext_pend (
    .clk(clk), .rst(rst), .lines_i(irq_i), .clr_i(ext_clr),
    .pend_o(pend_ext_q), .pend_nxt_o(pend_ext_nxt)
  );

  cpic_edge_pend #(.N(1)) u_nmi_pend (
    .clk(clk), .rst(rst), .lines_i(nmi_i), .clr_i(ack_nmi),
    .pend_o(nmi_pend_q), .pend_nxt_o(nmi_pend_nxt)
  );

  cpic_regs #(.NUM_LEVELS(NUM_LEVELS)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .pend_ext_i(pend_ext_q), .nmi_pend_i(nmi_pend_q),
    .en_o(en_q), .gie_o(gie_q), .en_nxt_o(en_nxt), .gie_nxt_o(gie_nxt),
    .sw_clr_o(sw_clr), .rdata_o(reg_rdata_o)
  );

  assign eligible = pend_ext_nxt & en_nxt & {N_EXT{gie_nxt}};

  cpic_prio_enc #(.N(N_EXT)) u_enc (
    .req_i(eligible), .valid_o(win_valid), .idx_o(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b1;
      level_q <= LVL_W'(LVL_RESET);
    end else if (nmi_pend_nxt) begin
      valid_q <= 1'b1;
      level_q <= LVL_W'(LVL_NMI);
    end else begin
      valid_q <= win_valid;
      level_q <= LVL_W'(EXT_BASE) + LVL_W'(win_idx);
    end
  end

  assign req_valid_o = valid_q;
  assign req_level_o = level_q;

  assert_reset_level0_R1: assert property (@(posedge clk)
    rst |=> (req_valid_o && req_level_o == LVL_W'(LVL_RESET)));

  assert_no_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_level_o != 2 && req_level_o != 3));

  assert_nmi_first_R5: assert property (@(posedge clk) disable iff (rst)
    nmi_pend_q |-> (req_valid_o && req_level_o == LVL_W'(LVL_NMI)));

  assert_masked_not_shown_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && req_level_o >= LVL_W'(EXT_BASE)) |->
      (gie_q && en_q[IDX_W'(req_level_o - LVL_W'(EXT_BASE))] &&
       pend_ext_q[IDX_W'(req_level_o - LVL_W'(EXT_BASE))]));
endmodule

// File: tb/core_prio_intc_tb.sv
module core_prio_intc_tb;
  logic        clk = 1'b0;
  logic        rst, nmi, ack, wr;
  logic [11:0] irq;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rvalid;
  logic [3:0]  rlevel;

  int    errs = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string cur = "R1";

  // behavioural reference state
  bit [15:0] m_pend, m_en;
  bit        m_gie, m_valid, m_prev_nmi;
  bit [11:0] m_prev_irq;
  int        m_level;
  bit [15:0] m_rdata;

  always #10 clk = ~clk;

  core_prio_intc u_dut (
    .clk(clk), .rst(rst), .nmi_i(nmi), .irq_i(irq), .ack_i(ack),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .req_valid_o(rvalid), .req_level_o(rlevel)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit [15:0] model_read(int a);
    case (a)
      0: return (m_en & 16'hFFF0) | {15'd0, m_gie};
      1: return m_pend & 16'hFFF2;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step();
    bit [15:0] clr;
    m_rdata = rst ? 16'h0 : model_read(int'(addr));
    if (rst) begin
      m_pend = '0; m_en = '0; m_gie = 0; m_valid = 1; m_level = 0;
    end else begin
      clr = '0;
      if (ack && m_valid && m_level != 0) clr[m_level] = 1'b1;
      if (wr && addr == 2'd2) clr = clr | (wdata & 16'hFFF0);
      m_pend = m_pend & ~clr;
      if (nmi && !m_prev_nmi) m_pend[1] = 1'b1;
      for (int k = 0; k < 12; k++)
        if (irq[k] && !m_prev_irq[k]) m_pend[k+4] = 1'b1;
      if (wr && addr == 2'd0) begin
        m_gie = wdata[0];
        m_en  = wdata & 16'hFFF0;
      end
      m_valid = 0; m_level = 4;
      if (m_pend[1]) begin
        m_valid = 1; m_level = 1;
      end else if (m_gie) begin
        for (int l = 15; l >= 4; l--)
          if (m_pend[l] && m_en[l]) begin m_valid = 1; m_level = l; end
      end
    end
    m_prev_irq = irq;
    m_prev_nmi = nmi;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(cur, "req_valid", int'(rvalid), int'(m_valid));
    if (m_valid) chk(cur, "req_level", int'(rlevel), m_level);
    chk(cur, "rdata", int'(rdata), int'(m_rdata));
  endtask

  task automatic expect_req(string tag, bit v, int l);
    chk(tag, "hand req_valid", int'(rvalid), int'(v));
    if (v) chk(tag, "hand req_level", int'(rlevel), l);
  endtask

  task automatic reg_wr(logic [1:0] a, logic [15:0] d);
    addr = a; wr = 1; wdata = d;
    tick();
    wr = 0; wdata = 0; addr = 0;
  endtask

  task automatic reg_rd(string tag, logic [1:0] a, int exp);
    addr = a;
    tick();
    chk(tag, "hand rdata", int'(rdata), exp);
    addr = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R1 act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    rst = 1; nmi = 0; ack = 0; wr = 0; irq = 0; addr = 0; wdata = 0;
    m_prev_irq = 0; m_prev_nmi = 0;
    // R1: reset shows level 0
    cur = "R1";
    repeat (3) tick();
    expect_req("R1", 1, 0);
    rst = 0;
    tick();
    expect_req("R1", 0, 0);

    // R2 / R4: capture while masked
    cur = "R2";
    irq[3] = 1; tick();
    expect_req("R4", 0, 0);
    reg_rd("R2", 2'd1, 16'h0080);
    cur = "R4";
    reg_wr(2'd0, 16'hFFF0);
    expect_req("R4", 0, 0);
    reg_wr(2'd0, 16'hFFF1);
    expect_req("R4", 1, 7);

    // R3 / R6: priority order and serial acknowledge
    cur = "R3";
    irq[8] = 1; irq[0] = 1; tick();
    expect_req("R3", 1, 4);
    cur = "R6";
    do_ack(); expect_req("R6", 1, 7);
    do_ack(); expect_req("R6", 1, 12);
    do_ack(); expect_req("R6", 0, 0);
    cur = "R2";
    tick(); expect_req("R2", 0, 0);  // lines still high, no re-capture
    irq = 0; tick();

    // R5: NMI ignores the global enable
    cur = "R5";
    reg_wr(2'd0, 16'hFFF0);
    nmi = 1; tick();
    expect_req("R5", 1, 1);
    cur = "R6";
    do_ack(); expect_req("R6", 0, 0);
    nmi = 0; tick();

    // R7: edge coinciding with acknowledge
    cur = "R7";
    reg_wr(2'd0, 16'hFFF1);
    irq[1] = 1; tick(); irq[1] = 0; tick();
    expect_req("R7", 1, 5);
    irq[1] = 1; ack = 1; tick(); ack = 0;
    expect_req("R7", 1, 5);
    do_ack(); expect_req("R6", 0, 0);
    irq[1] = 0; tick();

    // R8: write-one-to-clear, and R7 against a software clear
    cur = "R8";
    irq[8] = 1; tick(); expect_req("R8", 1, 12);
    reg_wr(2'd2, 16'h1000); expect_req("R8", 0, 0);
    irq[8] = 0; tick();
    cur = "R7";
    irq[8] = 1; reg_wr(2'd2, 16'h1000);
    expect_req("R7", 1, 12);
    cur = "R8";
    reg_wr(2'd2, 16'h0FFF);  // other bits only: stays
    expect_req("R8", 1, 12);
    reg_wr(2'd2, 16'h1000); expect_req("R8", 0, 0);
    irq[8] = 0; tick();

    // R10: registered reads, ignored writes, reserved bits
    cur = "R10";
    reg_wr(2'd1, 16'hFFFF);
    reg_rd("R10", 2'd1, 16'h0000);
    reg_wr(2'd0, 16'hFFFF);
    reg_rd("R10", 2'd0, 16'hFFF1);
    reg_rd("R10", 2'd3, 16'h0000);

    // R9 and masking per level
    cur = "R9";
    irq = 12'hFFF; nmi = 1; tick();
    irq = 0; nmi = 0; tick();
    expect_req("R5", 1, 1);
    reg_rd("R9", 2'd1, 16'hFFF2);
    reg_rd("R10", 2'd2, 16'h0000);
    cur = "R4";
    reg_wr(2'd0, 16'hFFE1);
    do_ack(); expect_req("R4", 1, 5);
    reg_wr(2'd0, 16'hFFE0); expect_req("R4", 0, 0);
    reg_wr(2'd0, 16'hFFF1); expect_req("R4", 1, 4);

    // R1: reset mid-operation clears everything
    cur = "R1";
    rst = 1; tick(); tick();
    expect_req("R1", 1, 0);
    rst = 0; tick();
    expect_req("R1", 0, 0);
    reg_rd("R1", 2'd1, 16'h0000);
    reg_rd("R1", 2'd0, 16'h0000);

    finish_run();
  end
endmodule